// File: doc/BRIEF.md
# Trap entry PC redirect unit

This unit sits between the pipeline's fault detection and instruction fetch. When the pipeline reports a fault, it supplies an encoded fault kind and the PC of the faulting instruction. One cycle later the unit issues a single-cycle redirect to the handler address. That address is the privileged handler base register plus a fixed entry offset chosen by the fault kind. Several kinds share one entry offset.

In the same cycle the unit updates the exception return-address register. The current PC is captured when the fault kind asks for a restart address, or when the PC is word aligned. Trap-class kinds then advance the saved address by one 4-byte instruction.

Each fault kind has its own event counter, so kinds that share an entry offset can still be told apart. The counters are read through a select/value port. Arithmetic-trap requests are not supported. Such a request produces no redirect and instead sets a sticky error flag.

Top module: `trap_redirect`

## Requirements
- R1: While `rst` is high at a clock edge, every event counter and `epc_val` clear to 0, `base_val` loads `BASE_RST`, `unimpl_err` clears, and after that edge `redir_valid` is 1 with `redir_pc` = `BASE_RST` + 0x0001.
- R2: The entry offset for each `flt_kind` code is: 0 reset 0x0001; 1 interrupt 0x0101; 2 instruction access violation 0x0081; 3 instruction TLB miss 0x0181; 4 single data TLB miss 0x0201; 5 double data TLB miss 0x0281; 6 data page fault 0x0381; 7 data access violation 0x0381; 8 unaligned 0x0301; 9 opcode decode 0x0481; 10 machine check 0x0401; 11 arithmetic (not taken, see R8); 12 integer overflow 0x0501; 13 float enable 0x0581; 14 vector enable 0x0581; 15 privileged call 0x2001.
- R3: A taken fault (`flt_valid` high at an edge, kind other than 11) makes `redir_valid` high for exactly the following cycle. In that cycle `redir_pc` equals the base register value held before that edge plus the offset from R2. With no taken fault, `redir_valid` is 0 in the following cycle.
- R4: `base_wr_en` high at an edge loads `base_wr_data` into the base register, which is visible on `base_val`. A fault taken at the same edge uses the old base value.
- R5: On a taken fault, `epc_val` loads `cur_pc` if the kind is a restart kind (codes 0, 2, 3) or if `cur_pc[1:0]` is 00. Otherwise it keeps its previous value.
- R6: For skip kinds (codes 12 and 15), 4 is added to the exception address after any capture from R5. If no capture took place, 4 is added to the old value.
- R7: Each taken fault increments, with wraparound, only the counter of its own kind. `cnt_val` shows the counter chosen by `cnt_sel`. Kinds 6 and 7, and kinds 13 and 14, are counted separately.
- R8: A request of kind 11 produces no redirect, changes no counter and leaves `epc_val` unchanged. It sets `unimpl_err`, which stays at 1 until reset.
- R9: With `flt_valid` low, `epc_val`, all counters and `unimpl_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault request this cycle |
| flt_kind | input | 4 | Encoded fault kind (R2 codes) |
| cur_pc | input | PC_W | PC of the faulting instruction |
| base_wr_en | input | 1 | Write strobe for the handler base register |
| base_wr_data | input | PC_W | New handler base value |
| cnt_sel | input | 4 | Kind whose counter is shown on cnt_val |
| base_val | output | PC_W | Current handler base register |
| epc_val | output | PC_W | Exception return-address register |
| cnt_val | output | CNT_W | Selected event counter |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | PC_W | Fetch redirect target |
| unimpl_err | output | 1 | Sticky flag: arithmetic trap requested |

## Verification
The assertions assume that `flt_kind` is meaningful only while `flt_valid` is high. They also assume that any upstream prioritising has already reduced simultaneous faults to a single kind per cycle. The stimulus therefore presents at most one kind per cycle. Kind codes, PCs with every low-bit pattern, and base writes are varied freely, including base writes that coincide with faults. Resets are applied only as whole cycles with inputs held stable, so no assertion ever sees a partial reset cycle.

// File: rtl/trap_redirect_pkg.sv
package trap_redirect_pkg;

  localparam int KIND_W    = 4;
  localparam int NUM_KINDS = 1 << KIND_W;
  localparam int VEC_W     = 14;

  typedef enum logic [KIND_W-1:0] {
    K_RESET  = 4'd0,
    K_INTR   = 4'd1,
    K_IACV   = 4'd2,
    K_IMISS  = 4'd3,
    K_DMISS1 = 4'd4,
    K_DMISS2 = 4'd5,
    K_DPAGE  = 4'd6,
    K_DACV   = 4'd7,
    K_UNALN  = 4'd8,
    K_OPDEC  = 4'd9,
    K_MCHK   = 4'd10,
    K_ARITH  = 4'd11,
    K_IOVF   = 4'd12,
    K_FEN    = 4'd13,
    K_VEN    = 4'd14,
    K_PCALL  = 4'd15
  } kind_e;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             restart;
    logic             skip;
    logic             unimpl;
  } kind_attr_t;

  function automatic logic [VEC_W-1:0] vec_of(kind_e k);
    case (k)
      K_RESET:          return 14'h0001;
      K_INTR:           return 14'h0101;
      K_IACV:           return 14'h0081;
      K_IMISS:          return 14'h0181;
      K_DMISS1:         return 14'h0201;
      K_DMISS2:         return 14'h0281;
      K_DPAGE, K_DACV:  return 14'h0381;
      K_UNALN:          return 14'h0301;
      K_OPDEC:          return 14'h0481;
      K_MCHK:           return 14'h0401;
      K_ARITH, K_IOVF:  return 14'h0501;
      K_FEN, K_VEN:     return 14'h0581;
      K_PCALL:          return 14'h2001;
      default:          return 14'h0001;
    endcase
  endfunction

  function automatic logic restart_of(kind_e k);
    return (k == K_RESET) || (k == K_IACV) || (k == K_IMISS);
  endfunction

  function automatic logic skip_of(kind_e k);
    return (k == K_IOVF) || (k == K_PCALL);
  endfunction

  function automatic kind_attr_t attr_of(kind_e k);
    kind_attr_t a;
    a.vec     = vec_of(k);
    a.restart = restart_of(k);
    a.skip    = skip_of(k);
    a.unimpl  = (k == K_ARITH);
    return a;
  endfunction

endpackage

// File: rtl/trap_kind_decode.sv
module trap_kind_decode
  import trap_redirect_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output kind_attr_t        attr
);

  always_comb attr = attr_of(kind_e'(kind));

  always_comb begin
    assert_vec_odd_R2: assert (attr.vec[0] == 1'b1);
    assert_flag_excl_R8: assert (!(attr.unimpl && (attr.skip || attr.restart)));
  end

endmodule

// File: rtl/trap_epc_unit.sv
module trap_epc_unit #(
  parameter int PC_W     = 32,
  parameter int INSN_BYT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            restart,
  input  logic            skip,
  output logic [PC_W-1:0] epc_q
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYT);

  function automatic logic [PC_W-1:0] advance(logic [PC_W-1:0] a);
    return a + STEP;
  endfunction

  logic            cap_en;
  logic            adv_en;
  logic [PC_W-1:0] captured;
  logic [PC_W-1:0] epc_d;

  assign cap_en   = take && (restart || (cur_pc[1:0] == 2'b00));
  assign adv_en   = take && skip;
  assign captured = cap_en ? cur_pc : epc_q;

  always_comb epc_d = adv_en ? advance(captured) : captured;

  always_ff @(posedge clk) begin
    if (rst) epc_q <= '0;
    else     epc_q <= epc_d;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(epc_q));
  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (take && !skip && (restart || cur_pc[1:0] == 2'b00)) |=> (epc_q == $past(cur_pc)));
  assert_nocap_R5: assert property (@(posedge clk) disable iff (rst)
    (take && !skip && !restart && cur_pc[1:0] != 2'b00) |=> $stable(epc_q));
  assert_skip_old_R6: assert property (@(posedge clk) disable iff (rst)
    (take && skip && !restart && cur_pc[1:0] != 2'b00) |=> (epc_q - $past(epc_q) == STEP));

endmodule

// File: rtl/trap_event_counters.sv
module trap_event_counters #(
  parameter int CNT_W  = 16,
  parameter int NUM    = 16,
  localparam int SEL_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [SEL_W-1:0] kind,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] val
);

  logic [CNT_W-1:0] cnt [NUM];
  logic [NUM-1:0]   hit;

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    assign hit[i] = take && (kind == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst)         cnt[i] <= '0;
      else if (hit[i]) cnt[i] <= cnt[i] + 1'b1;
    end

    assert_inc_R7: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> (cnt[i] == CNT_W'($past(cnt[i]) + 1)));
    assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
      !hit[i] |=> $stable(cnt[i]));
  end

  assign val = cnt[sel];

  assert_onehit_R7: assert property (@(posedge clk) disable iff (rst) $onehot0(hit));

endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
  import trap_redirect_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              CNT_W    = 16,
  parameter logic [PC_W-1:0] BASE_RST = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic [KIND_W-1:0] flt_kind,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              base_wr_en,
  input  logic [PC_W-1:0]   base_wr_data,
  input  logic [KIND_W-1:0] cnt_sel,
  output logic [PC_W-1:0]   base_val,
  output logic [PC_W-1:0]   epc_val,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic              unimpl_err
);

  localparam logic [PC_W-1:0] RESET_TGT = BASE_RST + PC_W'(vec_of(K_RESET));

  function automatic logic [PC_W-1:0] target(logic [PC_W-1:0] b, logic [VEC_W-1:0] v);
    return b + PC_W'(v);
  endfunction

  kind_attr_t      attr;
  logic            take;
  logic            arith_req;
  logic [PC_W-1:0] base_q;

  trap_kind_decode u_dec (.kind(flt_kind), .attr(attr));

  assign take      = flt_valid && !attr.unimpl;
  assign arith_req = flt_valid && attr.unimpl;

  always_ff @(posedge clk) begin
    if (rst)             base_q <= BASE_RST;
    else if (base_wr_en) base_q <= base_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b1;
      redir_pc    <= RESET_TGT;
      unimpl_err  <= 1'b0;
    end else begin
      redir_valid <= take;
      if (take) redir_pc <= target(base_q, attr.vec);
      if (arith_req) unimpl_err <= 1'b1;
    end
  end

  trap_epc_unit #(.PC_W(PC_W), .INSN_BYT(4)) u_epc (
    .clk(clk), .rst(rst), .take(take), .cur_pc(cur_pc),
    .restart(attr.restart), .skip(attr.skip), .epc_q(epc_val)
  );

  trap_event_counters #(.CNT_W(CNT_W), .NUM(NUM_KINDS)) u_cnt (
    .clk(clk), .rst(rst), .take(take), .kind(flt_kind),
    .sel(cnt_sel), .val(cnt_val)
  );

  assign base_val = base_q;

  assert_reset_tgt_R1: assert property (@(posedge clk)
    rst |=> (redir_valid && redir_pc == RESET_TGT && !unimpl_err));
  assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    !take |=> !redir_valid);
  assert_fire_R3: assert property (@(posedge clk) disable iff (rst)
    take |=> redir_valid);
  assert_oldbase_R4: assert property (@(posedge clk) disable iff (rst)
    (take && base_wr_en) |=> (redir_pc - $past(base_q) == PC_W'($past(attr.vec))));
  assert_basewr_R4: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |=> (base_val == $past(base_wr_data)));
  assert_arith_R8: assert property (@(posedge clk) disable iff (rst)
    arith_req |=> (!redir_valid && unimpl_err));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    unimpl_err |=> unimpl_err);

endmodule

// File: tb/trap_redirect_test.sv
module trap_redirect_test;

  localparam int          PC_W  = 32;
  localparam int          CNT_W = 16;
  localparam logic [31:0] BRST  = 32'h0000_8000;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst, flt_valid, base_wr_en;
  logic [3:0] flt_kind, cnt_sel;
  logic [PC_W-1:0] cur_pc, base_wr_data, base_val, epc_val, redir_pc;
  logic [CNT_W-1:0] cnt_val;
  logic redir_valid, unimpl_err;

  trap_redirect #(.PC_W(PC_W), .CNT_W(CNT_W), .BASE_RST(BRST)) uut (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_kind(flt_kind),
    .cur_pc(cur_pc), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .cnt_sel(cnt_sel), .base_val(base_val), .epc_val(epc_val),
    .cnt_val(cnt_val), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .unimpl_err(unimpl_err)
  );

  int n_chk = 0, n_bad = 0;

  // reference state
  int unsigned m_cnt [16];
  logic [31:0] m_epc, m_base, m_rpc;
  logic        m_rv, m_err;

  function automatic int unsigned offs(int k);
    int unsigned t [16] = '{32'h1, 32'h101, 32'h81, 32'h181, 32'h201, 32'h281,
                            32'h381, 32'h381, 32'h301, 32'h481, 32'h401, 32'h0,
                            32'h501, 32'h581, 32'h581, 32'h2001};
    return t[k];
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(bit in_rst);
    chk(in_rst ? "R1 redir_valid" : "R3 R9 redir_valid", redir_valid, m_rv);
    if (m_rv) chk(in_rst ? "R1 redir_pc" : "R2 R3 redir_pc", redir_pc, m_rpc);
    chk(in_rst ? "R1 epc" : "R5 R6 epc", epc_val, m_epc);
    chk(in_rst ? "R1 base" : "R4 base", base_val, m_base);
    chk(in_rst ? "R1 unimpl_err" : "R8 unimpl_err", unimpl_err, m_err);
    chk(in_rst ? "R1 counter" : "R7 counter", cnt_val, m_cnt[cnt_sel] & 32'hFFFF);
  endtask

  task automatic step(bit r, bit v, int k, logic [31:0] pc, bit we, logic [31:0] wd, int sel);
    logic [31:0] e;
    rst = r; flt_valid = v; flt_kind = 4'(k); cur_pc = pc;
    base_wr_en = we; base_wr_data = wd; cnt_sel = 4'(sel);
    @(posedge clk); #1;
    if (r) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_epc = 0; m_base = BRST; m_rv = 1; m_rpc = BRST + 1; m_err = 0;
    end else begin
      m_rv = 0;
      if (v && k == 11) m_err = 1;
      else if (v) begin
        m_rv = 1;
        m_rpc = m_base + offs(k);
        m_cnt[k] = (m_cnt[k] + 1) & 32'hFFFF;
        e = m_epc;
        if (k == 0 || k == 2 || k == 3 || pc[1:0] == 2'b00) e = pc;
        if (k == 12 || k == 15) e = e + 4;
        m_epc = e;
      end
      if (we) m_base = wd;
    end
    compare_all(r);
  endtask

  task automatic idle(int sel); step(0, 0, 0, 32'h0, 0, 32'h0, sel); endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 5);
    idle(0);
    // R2 every kind with aligned PC
    for (int k = 0; k < 16; k++) begin
      step(0, 1, k, 32'h1000 + 32'(k) * 16, 0, 0, k);
      idle(k);
    end
    // R5 misaligned, non-restart kind: epc kept
    step(0, 1, 1, 32'h4003, 0, 0, 1);
    // R5 misaligned, restart kind: captured
    step(0, 1, 3, 32'h5002, 0, 0, 3);
    // R6 skip, misaligned: old value advanced
    step(0, 1, 15, 32'h6001, 0, 0, 15);
    // R6 skip, aligned: captured then advanced
    step(0, 1, 12, 32'h7000, 0, 0, 12);
    // R8 arithmetic request then idle hold
    step(0, 1, 11, 32'h8000, 0, 0, 11);
    idle(11); idle(11);
    // R4 base write alone, then with coincident fault
    step(0, 0, 0, 0, 1, 32'h0010_0000, 0);
    step(0, 1, 6, 32'h9000, 1, 32'h0020_0000, 6);
    step(0, 1, 7, 32'h9004, 0, 0, 7);
    step(0, 1, 13, 32'h9008, 0, 0, 13);
    step(0, 1, 14, 32'h900c, 0, 0, 14);
    idle(7);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int rv = int'($urandom_range(0, 99));
      step(0, rv < 70, int'($urandom_range(0, 15)), $urandom,
           ($urandom_range(0, 9) == 0), $urandom & 32'hFFFF_FFF0, int'($urandom_range(0, 15)));
    end
    // R7 sweep all counters
    for (int k = 0; k < 16; k++) begin
      cnt_sel = 4'(k); #1;
      chk("R7 counter sweep", cnt_val, m_cnt[k] & 32'hFFFF);
    end
    // R7 wraparound on one counter
    for (int i = 0; i < 66000; i++) step(0, 1, 9, 32'h100, 0, 0, 9);
    // R1 second reset clears sticky error and counters
    step(1, 0, 0, 0, 0, 0, 9);
    for (int k = 0; k < 16; k++) begin
      cnt_sel = 4'(k); #1;
      chk("R1 counter clear", cnt_val, 0);
    end
    idle(0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule